// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block owns the output pin levels of a multi-channel timer (eight channels by default). Every channel keeps one state bit that drives its pin. The timer counters sit outside the block. Each channel reports a one-cycle event pulse when its counter reaches a terminal condition, and the controller turns those pulses into pin transitions. A channel can run in one of two ways:

- **Toggle mode.** Each of the channel's own events inverts the pin.
- **Paired set/reset mode.** This mode is for PWM. An odd-numbered channel takes the event of the even channel just below it as its start-of-period event, and takes its own event as its end-of-pulse event. A polarity bit chooses which of the two sets the pin and which clears it.

A small register interface holds four per-channel bit vectors: pin state, output enable, mode and polarity. Writes carry a bit mask, so a write changes only the selected channels. A separate read address returns any of the four vectors in the same cycle.

The output-enable bit separates hardware control from software control:

- **Enabled.** Only events move the pin, and software writes to the pin state are dropped.
- **Disabled.** Events are blocked, and software sets the idle level directly.

Top module: `tmr_pin_out`

## Requirements
- R1: While `rstN` is low, and directly after it is released, `pinOut` and all four register vectors read as zero.
- R2: In toggle mode (mode bit 0, or any even channel), an enabled channel's own event inverts its pin on the next clock edge, whatever its polarity bit holds.
- R3: In set/reset mode with polarity 0, an enabled odd channel n has its pin set by the event of channel n-1 and cleared by its own event, on the next edge.
- R4: In set/reset mode with polarity 1, the roles swap: the event of channel n-1 clears the pin of odd channel n and the channel's own event sets it.
- R5: When the set event and the clear event of a set/reset channel arrive in the same cycle, the pin ends at 0 (clear wins over set).
- R6: While a channel's enable bit is 0, no event changes its pin.
- R7: While a channel's enable bit is 1, a write to the state register leaves that channel's pin unchanged.
- R8: While a channel's enable bit is 0, a state write (address 0) whose mask bit is set loads the channel's data bit into its pin on the next edge, and channels whose mask bit is clear keep their level.
- R9: `busRdData` returns a register in the same cycle, selected by address: 0 for state (the current pin levels), 1 for enable, 2 for mode, 3 for polarity.
- R10: The mode bits of even-numbered channels are fixed at 0 and read back as 0 after any write.
- R11: A write to enable (address 1), mode (address 2) or polarity (address 3) updates only the channels whose mask bit is set, on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_CH | One-cycle event pulse of each timer channel |
| busWrEn | input | 1 | Register write strobe |
| busWrAddr | input | 2 | Register written: 0 state, 1 enable, 2 mode, 3 polarity |
| busWrData | input | NUM_CH | Write data, one bit per channel |
| busWrMask | input | NUM_CH | Channels affected by the write |
| busRdAddr | input | 2 | Register read, same encoding as busWrAddr |
| busRdData | output | NUM_CH | Read data for the selected register |
| pinOut | output | NUM_CH | Output pin levels |

## Verification
The bench goes after four corner cases:

- **0%-duty collision.** Both events of a set/reset pair arrive together. A design with the wrong priority would leave the pin high.
- **Enable race.** A state write and an event hit the same channel in one cycle while it is enabled. A design that lets software through would load the written bit instead of following the event. The reverse case, with the channel disabled, catches a design that leaks events.
- **Toggle channel with a set polarity bit.** This catches a design that consults polarity outside set/reset mode.
- **Mode write to even channels.** This catches a design that lets an even channel pair with a non-existent lower neighbour.

The bench also checks partial-mask writes. A design that ignores the mask would disturb channels outside it.

// File: rtl/tmr_pin_pkg.sv
package tmr_pin_pkg;

  typedef enum logic [1:0] {
    REG_STATE    = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_MODE     = 2'd2,
    REG_POLARITY = 2'd3
  } regAddr_t;

  // write strobes from control to datapath, one per register
  typedef struct packed {
    logic wrState;
    logic wrEnable;
    logic wrMode;
    logic wrPolarity;
  } regStrobe_t;

endpackage

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pin_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              busWrEn,
  input  logic [1:0]        busWrAddr,
  input  logic [NUM_CH-1:0] busWrMask,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic [NUM_CH-1:0] enQ,
  input  logic [NUM_CH-1:0] modeQ,
  input  logic [NUM_CH-1:0] polQ,
  output regStrobe_t        strobe,
  output logic [NUM_CH-1:0] swWrMask,
  output logic [NUM_CH-1:0] hwSet,
  output logic [NUM_CH-1:0] hwClr,
  output logic [NUM_CH-1:0] hwTog
);

  regAddr_t wrSel;

  always_comb begin
    wrSel             = regAddr_t'(busWrAddr);
    strobe            = '0;
    strobe.wrState    = busWrEn && (wrSel == REG_STATE);
    strobe.wrEnable   = busWrEn && (wrSel == REG_ENABLE);
    strobe.wrMode     = busWrEn && (wrSel == REG_MODE);
    strobe.wrPolarity = busWrEn && (wrSel == REG_POLARITY);
  end

  // software reaches the pin only where hardware control is off
  assign swWrMask = strobe.wrState ? (busWrMask & ~enQ) : '0;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic masterEvt;
    logic slaveEvt;
    logic setEvt;
    logic clrEvt;
    logic pairMode;

    if (n % 2 == 1) begin : g_odd
      assign masterEvt = evtIn[n-1];
    end else begin : g_even
      assign masterEvt = 1'b0;
    end

    assign slaveEvt = evtIn[n];
    assign pairMode = modeQ[n];
    assign setEvt   = polQ[n] ? slaveEvt  : masterEvt;
    assign clrEvt   = polQ[n] ? masterEvt : slaveEvt;

    assign hwClr[n] = enQ[n] &  pairMode & clrEvt;
    assign hwSet[n] = enQ[n] &  pairMode & setEvt & ~clrEvt;
    assign hwTog[n] = enQ[n] & ~pairMode & slaveEvt;
  end

endmodule

// File: rtl/tmr_pin_dp.sv
module tmr_pin_dp
  import tmr_pin_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] cfgMask,
  input  logic [NUM_CH-1:0] swWrMask,
  input  logic [NUM_CH-1:0] hwSet,
  input  logic [NUM_CH-1:0] hwClr,
  input  logic [NUM_CH-1:0] hwTog,
  input  logic [1:0]        rdAddr,
  output logic [NUM_CH-1:0] rdData,
  output logic [NUM_CH-1:0] stQ,
  output logic [NUM_CH-1:0] enQ,
  output logic [NUM_CH-1:0] modeQ,
  output logic [NUM_CH-1:0] polQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      polQ <= '0;
    end else begin
      if (strobe.wrEnable)   enQ  <= (enQ  & ~cfgMask) | (wrData & cfgMask);
      if (strobe.wrPolarity) polQ <= (polQ & ~cfgMask) | (wrData & cfgMask);
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    if (n % 2 == 1) begin : g_modeFf
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                           modeQ[n] <= 1'b0;
        else if (strobe.wrMode && cfgMask[n]) modeQ[n] <= wrData[n];
      end
    end else begin : g_modeTie
      assign modeQ[n] = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            stQ[n] <= 1'b0;
      else if (swWrMask[n]) stQ[n] <= wrData[n];
      else if (hwClr[n])    stQ[n] <= 1'b0;
      else if (hwSet[n])    stQ[n] <= 1'b1;
      else if (hwTog[n])    stQ[n] <= ~stQ[n];
    end
  end

  always_comb begin
    unique case (regAddr_t'(rdAddr))
      REG_STATE:    rdData = stQ;
      REG_ENABLE:   rdData = enQ;
      REG_MODE:     rdData = modeQ;
      REG_POLARITY: rdData = polQ;
      default:      rdData = stQ;
    endcase
  end

endmodule

// File: rtl/tmr_pin_out.sv
module tmr_pin_out
  import tmr_pin_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic              busWrEn,
  input  logic [1:0]        busWrAddr,
  input  logic [NUM_CH-1:0] busWrData,
  input  logic [NUM_CH-1:0] busWrMask,
  input  logic [1:0]        busRdAddr,
  output logic [NUM_CH-1:0] busRdData,
  output logic [NUM_CH-1:0] pinOut
);

  regStrobe_t        strobe;
  logic [NUM_CH-1:0] swWrMask;
  logic [NUM_CH-1:0] hwSet;
  logic [NUM_CH-1:0] hwClr;
  logic [NUM_CH-1:0] hwTog;
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] modeQ;
  logic [NUM_CH-1:0] polQ;

  tmr_pin_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .busWrEn   (busWrEn),
    .busWrAddr (busWrAddr),
    .busWrMask (busWrMask),
    .evtIn     (evtIn),
    .enQ       (enQ),
    .modeQ     (modeQ),
    .polQ      (polQ),
    .strobe    (strobe),
    .swWrMask  (swWrMask),
    .hwSet     (hwSet),
    .hwClr     (hwClr),
    .hwTog     (hwTog)
  );

  tmr_pin_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .cfgMask  (busWrMask),
    .swWrMask (swWrMask),
    .hwSet    (hwSet),
    .hwClr    (hwClr),
    .hwTog    (hwTog),
    .rdAddr   (busRdAddr),
    .rdData   (busRdData),
    .stQ      (pinOut),
    .enQ      (enQ),
    .modeQ    (modeQ),
    .polQ     (polQ)
  );

endmodule

// File: rtl/tmr_pin_out_chk.sv
module tmr_pin_out_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] evtIn,
  input logic              busWrEn,
  input logic [1:0]        busWrAddr,
  input logic [NUM_CH-1:0] busWrData,
  input logic [NUM_CH-1:0] busWrMask,
  input logic [NUM_CH-1:0] pinOut,
  input logic [NUM_CH-1:0] enQ,
  input logic [NUM_CH-1:0] modeQ,
  input logic [NUM_CH-1:0] polQ
);

  logic stWr;
  assign stWr = busWrEn && (busWrAddr == 2'd0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // R6: a disabled channel without a state write holds its level
    p_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!enQ[n] && !(stWr && busWrMask[n])) |=> $stable(pinOut[n]));

    // R8: a masked state write on a disabled channel loads the data bit
    p_swload_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!enQ[n] && stWr && busWrMask[n]) |=> (pinOut[n] == $past(busWrData[n])));

    // R2: toggle mode flips on the channel's own event
    p_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
      (enQ[n] && !modeQ[n] && evtIn[n]) |=> (pinOut[n] != $past(pinOut[n])));

    if (n % 2 == 1) begin : g_pair
      // R7: enabled channel without a relevant event ignores software
      p_swignored_r7: assert property (@(posedge clk) disable iff (!rstN)
        (enQ[n] && !evtIn[n] && !(modeQ[n] && evtIn[n-1])) |=> $stable(pinOut[n]));

      // R5: simultaneous set and clear leaves the pin low
      p_collide_r5: assert property (@(posedge clk) disable iff (!rstN)
        (enQ[n] && modeQ[n] && evtIn[n] && evtIn[n-1]) |=> !pinOut[n]);

      // R3: polarity 0, lone master event sets the pin
      p_setfwd_r3: assert property (@(posedge clk) disable iff (!rstN)
        (enQ[n] && modeQ[n] && !polQ[n] && evtIn[n-1] && !evtIn[n]) |=> pinOut[n]);

      // R4: polarity 1, lone own event sets the pin
      p_setrev_r4: assert property (@(posedge clk) disable iff (!rstN)
        (enQ[n] && modeQ[n] && polQ[n] && evtIn[n] && !evtIn[n-1]) |=> pinOut[n]);
    end else begin : g_solo
      // R7: enabled even channel without its own event ignores software
      p_swignored_r7: assert property (@(posedge clk) disable iff (!rstN)
        (enQ[n] && !evtIn[n]) |=> $stable(pinOut[n]));
    end
  end

endmodule

bind tmr_pin_out tmr_pin_out_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .busWrEn   (busWrEn),
  .busWrAddr (busWrAddr),
  .busWrData (busWrData),
  .busWrMask (busWrMask),
  .pinOut    (pinOut),
  .enQ       (enQ),
  .modeQ     (modeQ),
  .polQ      (polQ)
);

// File: tb/tmr_pin_out_bench.sv
module tmr_pin_out_bench;

  localparam int NUM_CH   = 8;
  localparam int CLK_PER  = 10;
  localparam int N_RAND   = 4000;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] evtIn = '0;
  logic              busWrEn = 1'b0;
  logic [1:0]        busWrAddr = '0;
  logic [NUM_CH-1:0] busWrData = '0;
  logic [NUM_CH-1:0] busWrMask = '0;
  logic [1:0]        busRdAddr = '0;
  logic [NUM_CH-1:0] busRdData;
  logic [NUM_CH-1:0] pinOut;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // reference state
  logic [NUM_CH-1:0] mSt, mEn, mMode, mPol;
  string tagOf [NUM_CH];

  always #(CLK_PER/2) clk = ~clk;

  tmr_pin_out #(.NUM_CH(NUM_CH)) u_tmr_pin_out (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busWrEn(busWrEn),
    .busWrAddr(busWrAddr), .busWrData(busWrData), .busWrMask(busWrMask),
    .busRdAddr(busRdAddr), .busRdData(busRdData), .pinOut(pinOut)
  );

  task automatic check(string tag, logic [NUM_CH-1:0] act, logic [NUM_CH-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NUM_CH-1:0] modelRead(logic [1:0] a);
    case (a)
      2'd0: return mSt;
      2'd1: return mEn;
      2'd2: return mMode;
      default: return mPol;
    endcase
  endfunction

  // compare all outputs against the reference at a negedge
  task automatic compareNow();
    for (int n = 0; n < NUM_CH; n++) begin
      nCmp++;
      if (pinOut[n] !== mSt[n]) begin
        nBad++;
        $display("FAIL %s: pin %0d actual %b expected %b at %0t",
                 tagOf[n], n, pinOut[n], mSt[n], $time);
      end
    end
    case (busRdAddr)
      2'd0: check("R9 state read", busRdData, modelRead(busRdAddr));
      2'd2: check("R10 mode read", busRdData, modelRead(busRdAddr));
      default: check("R11 config read", busRdData, modelRead(busRdAddr));
    endcase
  endtask

  // advance the reference by one clock given the driven inputs
  task automatic modelStep();
    logic [NUM_CH-1:0] nSt;
    nSt = mSt;
    for (int n = 0; n < NUM_CH; n++) begin
      bit swHit, pair, mEv, sEv, setE, clrE;
      swHit = busWrEn && busWrAddr == 2'd0 && busWrMask[n];
      pair  = (n % 2 == 1) && mMode[n];
      mEv   = (n % 2 == 1) ? evtIn[n-1] : 1'b0;
      sEv   = evtIn[n];
      setE  = mPol[n] ? sEv : mEv;
      clrE  = mPol[n] ? mEv : sEv;
      if (!mEn[n]) begin
        tagOf[n] = swHit ? "R8" : "R6";
        if (swHit) nSt[n] = busWrData[n];
      end else if (pair) begin
        if (setE && clrE) begin tagOf[n] = "R5"; nSt[n] = 1'b0; end
        else if (clrE)    begin tagOf[n] = mPol[n] ? "R4" : "R3"; nSt[n] = 1'b0; end
        else if (setE)    begin tagOf[n] = mPol[n] ? "R4" : "R3"; nSt[n] = 1'b1; end
        else tagOf[n] = "R7";
      end else begin
        if (sEv) begin tagOf[n] = "R2"; nSt[n] = ~mSt[n]; end
        else tagOf[n] = "R7";
      end
    end
    mSt = nSt;
    if (busWrEn) begin
      case (busWrAddr)
        2'd1: mEn   = (mEn  & ~busWrMask) | (busWrData & busWrMask);
        2'd2: mMode = ((mMode & ~busWrMask) | (busWrData & busWrMask)) & {(NUM_CH/2){2'b10}};
        2'd3: mPol  = (mPol & ~busWrMask) | (busWrData & busWrMask);
        default: ;
      endcase
    end
  endtask

  // drive one cycle of stimulus at a negedge, after comparing
  task automatic cycle(logic [NUM_CH-1:0] ev, bit we, logic [1:0] wa,
                       logic [NUM_CH-1:0] wd, logic [NUM_CH-1:0] wm);
    @(negedge clk);
    compareNow();
    evtIn = ev; busWrEn = we; busWrAddr = wa; busWrData = wd; busWrMask = wm;
    busRdAddr = busRdAddr + 2'd1;
    modelStep();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    mSt = '0; mEn = '0; mMode = '0; mPol = '0;
    for (int n = 0; n < NUM_CH; n++) tagOf[n] = "R1";
    repeat (2) @(negedge clk);
    // R1: reset values on all registers and pins
    for (int a = 0; a < 4; a++) begin
      busRdAddr = 2'(a);
      #1 check("R1 reset read", busRdData, '0);
    end
    check("R1 reset pins", pinOut, '0);
    busRdAddr = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", pinOut, '0);

    // R8: disabled software load with partial mask
    cycle('0, 1, 2'd0, 8'hFF, 8'h0F);
    cycle('0, 1, 2'd0, 8'h00, 8'h05);
    // R10: mode write to all channels, even ones stay 0
    cycle('0, 1, 2'd2, 8'hFF, 8'hFF);
    // R11: polarity on upper half, enable all
    cycle('0, 1, 2'd3, 8'hF0, 8'hFF);
    cycle('0, 1, 2'd1, 8'hFF, 8'hFF);
    // R3/R4: master events set/clear paired channels
    cycle(8'h55, 0, 2'd0, '0, '0);
    cycle(8'hAA, 0, 2'd0, '0, '0);
    // R5: both events together
    cycle(8'hFF, 0, 2'd0, '0, '0);
    // R7: writes while enabled are dropped
    cycle('0, 1, 2'd0, 8'hFF, 8'hFF);
    // R2: toggle with polarity set on even channels
    cycle(8'h10, 0, 2'd0, '0, '0);
    // R6: disable, then events have no effect
    cycle('0, 1, 2'd1, 8'h00, 8'hFF);
    cycle(8'hFF, 0, 2'd0, '0, '0);
    cycle(8'hFF, 0, 2'd0, '0, '0);

    for (int i = 0; i < N_RAND; i++) begin
      logic [NUM_CH-1:0] ev, wd, wm;
      bit we;
      for (int n = 0; n < NUM_CH; n++) ev[n] = ($urandom_range(0, 3) == 0);
      we = ($urandom_range(0, 9) < 3);
      wd = NUM_CH'($urandom);
      wm = ($urandom_range(0, 1) == 0) ? NUM_CH'(1 << $urandom_range(0, NUM_CH-1))
                                       : NUM_CH'($urandom);
      cycle(ev, we, 2'($urandom_range(0, 3)), wd, wm);
    end
    cycle('0, 0, 2'd0, '0, '0);
    @(negedge clk);
    compareNow();
    finishRun();
  end

endmodule